// File: doc/BRIEF.md
# Memory-Mapped Serial NOR Flash Engine

This block connects one serial NOR flash chip select to a simple word/byte bus through an address window. A 32-bit control word picks how window accesses are turned into serial traffic. The block drives chip select, the serial clock and four bidirectional data lines, each line with its own output enable. Serial clock timing comes from an external divider pulse, `sck_tick`. Each pulse advances the serial clock by half a period.

In user mode, software frames the flash transaction itself. Clearing the stop bit pulls chip select low. Each window write then shifts its bytes out, most significant byte first. Each window read shifts bytes in. Setting the stop bit again ends the frame. The lane width can be changed between accesses inside the same frame, so the opcode and address can go out on one lane while the data uses two or four. In command-read mode, a single window read expands into a complete flash read without software help. The engine sends the opcode from the control word, then the window offset as the address, then zero dummy bytes, and shifts in the requested bytes at the configured width. Normal-read mode uses the same sequence with a fixed slow-read opcode. The bus waits on a ready pulse until the last byte has arrived.

Top module: `sfl_window_engine`

## Requirements
- R1: After reset: chip select is high, the serial clock is low, all data output enables are 0, ready is low, and the control word reads back 0x00000004 (normal-read mode with stop set).
- R2: The control word is written whole and reads back as written. Its fields are:
  - mode in [1:0]: 0 normal read, 1 command read, 2 command write (not supported), 3 user;
  - stop in [2];
  - dummy count in [7:6] plus four times [14];
  - read opcode in [23:16];
  - width in [30:28]: bit 30 selects four lanes, otherwise bit 29 selects two lanes, otherwise one lane.
- R3: In user mode, chip select follows the stop bit. Stop set means high and stop clear means low.
- R4: A user-mode window write sends `win_wdata[7:0]` for a byte access, or all four bytes starting with [31:24] for a word access. Each byte goes out most significant bit first.
- R5: A user-mode window read shifts in one byte into `win_rdata[7:0]` with the upper bits zero, or four bytes with the first byte in [31:24]. With one lane, input is sampled from data line 1.
- R6: With two lanes each serial clock carries two bits on lines 1:0, higher bit on line 1. With four lanes each clock carries a nibble on lines 3:0, high nibble first. The width can change between user accesses without dropping chip select.
- R7: Serial clock mode 0: the clock idles low, output data changes only while the clock is low, and the clock changes level only on cycles where `sck_tick` is high.
- R8: A command-mode read of N bytes (1 or 4) does the following, then ends with one ready pulse:
  - lowers chip select once;
  - sends the opcode, three address bytes taken from the window offset (most significant first), and the configured number of zero dummy bytes, all on one lane;
  - shifts in N bytes at the configured width;
  - raises chip select.
- R9: When `addr_wide` is high at the start of a command read, four address bytes are sent: the window offset zero-extended to 32 bits.
- R10: A window read in normal-read mode uses opcode 0x03, no dummy bytes and a single data lane, whatever the opcode, dummy and width fields hold.
- R11: Output enables are 0001 for one-lane output, 0011 for two lanes and 1111 for four lanes. They are 0000 during input phases and when idle.
- R12: Window writes in modes 0, 1 and 2, and window reads in mode 2, complete with ready within two cycles. They cause no chip-select or clock activity, and the read data is 0.
- R13: Ready is a single-cycle pulse, and the bus request is held until it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Current control word |
| addr_wide | input | 1 | Four address bytes in command reads |
| sck_tick | input | 1 | Divider pulse, one serial clock half period |
| win_req | input | 1 | Window access request, held until ready |
| win_we | input | 1 | Window access is a write |
| win_word | input | 1 | 1: four-byte access, 0: one-byte access |
| win_addr | input | AW | Byte offset inside the window |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, valid with ready |
| win_ready | output | 1 | Access complete pulse |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_out | output | 4 | Data line output values |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_in | input | 4 | Data line input values |

## Verification
The bench targets the following cases, and what a broken design would do in each:

- **Phase-count extremes.** Command reads use seven dummy bytes, zero dummy bytes, and both three- and four-byte addresses. A sequencer that mishandles a count boundary emits a wrong bit stream, and a byte-count comparison catches it.
- **Lane selection.** The read response drives the unused input lanes with inverted bits. Sampling the wrong line, or packing dual or quad bits in the wrong order, therefore corrupts the returned word.
- **Normal-read override and silent accesses.** Normal-read mode is given deliberately misleading opcode, dummy and width fields. Writes in the non-user modes must produce no clock edges at all.
- **Timing.** The divider pulse is randomised, and a monitor flags any change of output data while the clock is high.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_CMDRD  = 2'd1,
    MD_CMDWR  = 2'd2,
    MD_USER   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    LN_X1 = 2'd0,
    LN_X2 = 2'd1,
    LN_X4 = 2'd2
  } lanes_e;

  localparam logic [31:0] CFG_RESET   = 32'h0000_0004;
  localparam int          CFG_STOP    = 2;
  localparam int          CFG_DMY_HI  = 14;
  localparam int          CFG_OP_LSB  = 16;
  localparam int          CFG_W_DUAL  = 29;
  localparam int          CFG_W_QUAD  = 30;
  localparam logic [7:0]  SLOW_READ_OP = 8'h03;

  function automatic lanes_e decode_lanes(input logic quad, input logic dual);
    if (quad)      return LN_X4;
    else if (dual) return LN_X2;
    else           return LN_X1;
  endfunction

endpackage

// File: rtl/sfl_shifter.sv
module sfl_shifter
  import sfl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       drive,
  input  lanes_e     lanes,
  input  logic [3:0] io_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);

  logic       act_q, act_d;
  logic       sck_q, sck_d;
  logic       drv_q, drv_d;
  logic       done_q, done_d;
  logic [7:0] sh_q, sh_d;
  logic [7:0] rx_q, rx_d;
  logic [2:0] left_q, left_d;
  lanes_e     lw_q, lw_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    drv_d  = drv_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    left_d = left_q;
    lw_d   = lw_q;
    done_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      sck_d = 1'b0;
      drv_d = drive;
      sh_d  = tx_byte;
      rx_d  = 8'h00;
      lw_d  = lanes;
      case (lanes)
        LN_X1:   left_d = 3'd7;
        LN_X2:   left_d = 3'd3;
        default: left_d = 3'd1;
      endcase
    end else if (act_q && tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        case (lw_q)
          LN_X1:   rx_d = {rx_q[6:0], io_in[1]};
          LN_X2:   rx_d = {rx_q[5:0], io_in[1:0]};
          default: rx_d = {rx_q[3:0], io_in};
        endcase
      end else begin
        sck_d = 1'b0;
        if (left_q == 3'd0) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          left_d = left_q - 3'd1;
          case (lw_q)
            LN_X1:   sh_d = {sh_q[6:0], 1'b0};
            LN_X2:   sh_d = {sh_q[5:0], 2'b00};
            default: sh_d = {sh_q[3:0], 4'h0};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      drv_q  <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= 8'h00;
      rx_q   <= 8'h00;
      left_q <= 3'd0;
      lw_q   <= LN_X1;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      drv_q  <= drv_d;
      done_q <= done_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      left_q <= left_d;
      lw_q   <= lw_d;
    end
  end

  always_comb begin
    io_oe  = 4'b0000;
    io_out = 4'b0000;
    case (lw_q)
      LN_X1: begin
        io_out = {3'b000, sh_q[7]};
        if (act_q && drv_q) io_oe = 4'b0001;
      end
      LN_X2: begin
        io_out = {2'b00, sh_q[7:6]};
        if (act_q && drv_q) io_oe = 4'b0011;
      end
      default: begin
        io_out = sh_q[7:4];
        if (act_q && drv_q) io_oe = 4'b1111;
      end
    endcase
  end

  assign busy    = act_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sck     = sck_q;

  // R7: the serial clock only moves on divider pulses
  assert_sck_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sck_q));

  // R8: the sequencer never restarts a byte still in flight
  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !act_q);

endmodule

// File: rtl/sfl_sequencer.sv
module sfl_sequencer
  import sfl_pkg::*;
#(
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic [7:0]    opcode,
  input  logic [2:0]    dummy_n,
  input  lanes_e        data_lanes,
  input  logic          addr_wide,
  input  logic          req,
  input  logic          we,
  input  logic          word,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          ready,
  output logic          seq_cs_n,
  output logic          sh_start,
  output logic [7:0]    sh_tx,
  output logic          sh_drive,
  output lanes_e        sh_lanes,
  input  logic          sh_done,
  input  logic [7:0]    sh_rx
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_ACK} state_e;
  typedef enum logic [1:0] {PH_OP, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;

  localparam logic [2:0] NB_WORD = 3'd4;
  localparam logic [2:0] NB_BYTE = 3'd1;

  state_e      st_q, st_d;
  phase_e      ph_q, ph_d;
  logic [2:0]  cnt_q, cnt_d;
  logic [2:0]  nb_q, nb_d;
  logic [2:0]  dmy_q, dmy_d;
  logic [7:0]  op_q, op_d;
  lanes_e      ln_q, ln_d;
  logic        rd_q, rd_d;
  logic        aw_q, aw_d;
  logic        cs_q, cs_d;
  logic [31:0] sh_q, sh_d;
  logic [31:0] acc_q, acc_d;
  logic [31:0] addr32;

  assign addr32 = 32'(addr);

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    cnt_d = cnt_q;
    nb_d  = nb_q;
    dmy_d = dmy_q;
    op_d  = op_q;
    ln_d  = ln_q;
    rd_d  = rd_q;
    aw_d  = aw_q;
    cs_d  = cs_q;
    sh_d  = sh_q;
    acc_d = acc_q;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          acc_d = 32'h0;
          nb_d  = word ? NB_WORD : NB_BYTE;
          if (mode == MD_USER) begin
            ph_d  = PH_DATA;
            cnt_d = word ? NB_WORD : NB_BYTE;
            rd_d  = !we;
            ln_d  = data_lanes;
            sh_d  = word ? wdata : {wdata[7:0], 24'h0};
            st_d  = ST_LOAD;
          end else if (!we && (mode == MD_NORMAL || mode == MD_CMDRD)) begin
            cs_d  = 1'b0;
            ph_d  = PH_OP;
            cnt_d = 3'd1;
            rd_d  = 1'b1;
            aw_d  = addr_wide;
            op_d  = (mode == MD_NORMAL) ? SLOW_READ_OP : opcode;
            dmy_d = (mode == MD_NORMAL) ? 3'd0 : dummy_n;
            ln_d  = (mode == MD_NORMAL) ? LN_X1 : data_lanes;
            sh_d  = addr_wide ? addr32 : {addr32[23:0], 8'h00};
            st_d  = ST_LOAD;
          end else begin
            st_d = ST_ACK;
          end
        end
      end
      ST_LOAD: st_d = ST_WAIT;
      ST_WAIT: begin
        if (sh_done) begin
          if (ph_q == PH_DATA && rd_q) acc_d = {acc_q[23:0], sh_rx};
          if (ph_q == PH_ADDR || (ph_q == PH_DATA && !rd_q)) sh_d = {sh_q[23:0], 8'h00};
          st_d = ST_LOAD;
          if (cnt_q == 3'd1) begin
            case (ph_q)
              PH_OP: begin
                ph_d  = PH_ADDR;
                cnt_d = aw_q ? 3'd4 : 3'd3;
              end
              PH_ADDR: begin
                if (dmy_q != 3'd0) begin
                  ph_d  = PH_DUMMY;
                  cnt_d = dmy_q;
                end else begin
                  ph_d  = PH_DATA;
                  cnt_d = nb_q;
                end
              end
              PH_DUMMY: begin
                ph_d  = PH_DATA;
                cnt_d = nb_q;
              end
              default: begin
                cs_d = 1'b1;
                st_d = ST_ACK;
              end
            endcase
          end else begin
            cnt_d = cnt_q - 3'd1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_OP;
      cnt_q <= 3'd0;
      nb_q  <= 3'd0;
      dmy_q <= 3'd0;
      op_q  <= 8'h00;
      ln_q  <= LN_X1;
      rd_q  <= 1'b0;
      aw_q  <= 1'b0;
      cs_q  <= 1'b1;
      sh_q  <= 32'h0;
      acc_q <= 32'h0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      nb_q  <= nb_d;
      dmy_q <= dmy_d;
      op_q  <= op_d;
      ln_q  <= ln_d;
      rd_q  <= rd_d;
      aw_q  <= aw_d;
      cs_q  <= cs_d;
      sh_q  <= sh_d;
      acc_q <= acc_d;
    end
  end

  always_comb begin
    case (ph_q)
      PH_OP:    sh_tx = op_q;
      PH_DUMMY: sh_tx = 8'h00;
      default:  sh_tx = sh_q[31:24];
    endcase
  end

  assign sh_start = (st_q == ST_LOAD);
  assign sh_drive = !(ph_q == PH_DATA && rd_q);
  assign sh_lanes = (ph_q == PH_DATA) ? ln_q : LN_X1;
  assign ready    = (st_q == ST_ACK);
  assign rdata    = acc_q;
  assign seq_cs_n = cs_q;

  // R13: completion is a single-cycle pulse
  assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

endmodule

// File: rtl/sfl_window_engine.sv
module sfl_window_engine
  import sfl_pkg::*;
#(
  parameter int AW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          addr_wide,
  input  logic          sck_tick,
  input  logic          win_req,
  input  logic          win_we,
  input  logic          win_word,
  input  logic [AW-1:0] win_addr,
  input  logic [31:0]   win_wdata,
  output logic [31:0]   win_rdata,
  output logic          win_ready,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic [3:0]    spi_io_out,
  output logic [3:0]    spi_io_oe,
  input  logic [3:0]    spi_io_in
);

  logic [31:0] cfg_q, cfg_d;
  mode_e       cur_mode;
  lanes_e      cur_lanes;
  logic [2:0]  cur_dummy;
  logic [7:0]  cur_op;

  logic        sh_start, sh_drive, sh_busy, sh_done;
  logic [7:0]  sh_tx, sh_rx;
  lanes_e      sh_lanes;
  logic        seq_cs_n;

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr_en) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cur_mode  = mode_e'(cfg_q[1:0]);
  assign cur_dummy = {cfg_q[CFG_DMY_HI], cfg_q[7:6]};
  assign cur_op    = cfg_q[CFG_OP_LSB +: 8];
  assign cur_lanes = decode_lanes(cfg_q[CFG_W_QUAD], cfg_q[CFG_W_DUAL]);
  assign cfg_rdata = cfg_q;

  sfl_sequencer #(.AW(AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (cur_mode),
    .opcode     (cur_op),
    .dummy_n    (cur_dummy),
    .data_lanes (cur_lanes),
    .addr_wide  (addr_wide),
    .req        (win_req),
    .we         (win_we),
    .word       (win_word),
    .addr       (win_addr),
    .wdata      (win_wdata),
    .rdata      (win_rdata),
    .ready      (win_ready),
    .seq_cs_n   (seq_cs_n),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .sh_drive   (sh_drive),
    .sh_lanes   (sh_lanes),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx)
  );

  sfl_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sck_tick),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .drive   (sh_drive),
    .lanes   (sh_lanes),
    .io_in   (spi_io_in),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx),
    .sck     (spi_sck),
    .io_out  (spi_io_out),
    .io_oe   (spi_io_oe)
  );

  assign spi_cs_n = (cur_mode == MD_USER) ? cfg_q[CFG_STOP] : seq_cs_n;

  // R11: enables only take the one, two or four lane shapes
  assert_oe_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_io_oe == 4'b0000) || (spi_io_oe == 4'b0001) ||
    (spi_io_oe == 4'b0011) || (spi_io_oe == 4'b1111));

  // R8: outside user mode no clock pulse while chip select is released
  assert_quiet_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode != MD_USER && spi_cs_n) |-> !spi_sck);

  // R7: data held while the clock is high
  assert_hold_while_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck) && sh_busy) |-> $stable(spi_io_out));

endmodule

// File: tb/sfl_window_engine_test.sv
module sfl_window_engine_test;
  localparam int AW = 26;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr_en;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          addr_wide;
  logic          sck_tick;
  logic          win_req, win_we, win_word;
  logic [AW-1:0] win_addr;
  logic [31:0]   win_wdata, win_rdata;
  logic          win_ready;
  logic          spi_cs_n, spi_sck;
  logic [3:0]    spi_io_out, spi_io_oe, spi_io_in;

  sfl_window_engine #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .addr_wide(addr_wide), .sck_tick(sck_tick),
    .win_req(win_req), .win_we(win_we), .win_word(win_word), .win_addr(win_addr),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .win_ready(win_ready),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_io_out(spi_io_out),
    .spi_io_oe(spi_io_oe), .spi_io_in(spi_io_in)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;

  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt = 0;
      sck_tick = 1'b1;
    end else begin
      tick_cnt = tick_cnt + 1;
      sck_tick = 1'b0;
    end
  end

  // flash-side monitor and responder
  bit         obits [0:511];
  bit         ebits [0:511];
  int         out_n, exp_n, out_beats, exp_beats, in_beats, cs_falls, sck_rises;
  logic [3:0] oe_or, oe_and;
  bit         last_in;
  logic [31:0] resp = 32'h0;
  int         rlanes = 1;
  int         viol = 0;
  logic       prev_sck = 1'b0;
  logic [3:0] prev_out = 4'h0;
  logic [3:0] prev_oe = 4'h0;

  assign spi_io_in = (rlanes == 1) ? {~resp[31], ~resp[31], resp[31], ~resp[31]} :
                     (rlanes == 2) ? {~resp[31:30], resp[31:30]} : resp[31:28];

  task automatic push_bit(input logic b);
    if (out_n < 512) obits[out_n] = b;
    out_n++;
  endtask

  always @(posedge spi_sck) begin
    sck_rises++;
    if (spi_io_oe != 4'h0) begin
      out_beats++;
      oe_or  = oe_or | spi_io_oe;
      oe_and = oe_and & spi_io_oe;
      last_in = 1'b0;
      if (spi_io_oe == 4'b0001) push_bit(spi_io_out[0]);
      else if (spi_io_oe == 4'b0011) begin
        push_bit(spi_io_out[1]); push_bit(spi_io_out[0]);
      end else begin
        push_bit(spi_io_out[3]); push_bit(spi_io_out[2]);
        push_bit(spi_io_out[1]); push_bit(spi_io_out[0]);
      end
    end else begin
      in_beats++;
      last_in = 1'b1;
    end
  end

  always @(negedge spi_sck) if (last_in) resp = resp << rlanes;
  always @(negedge spi_cs_n) cs_falls++;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && spi_sck && prev_sck && prev_oe != 4'h0 &&
        spi_io_oe != 4'h0 && spi_io_out != prev_out) viol++;
    prev_sck = spi_sck;
    prev_out = spi_io_out;
    prev_oe  = spi_io_oe;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
    end
  endtask

  task automatic clear_mon();
    out_n = 0; exp_n = 0; out_beats = 0; exp_beats = 0; in_beats = 0;
    cs_falls = 0; sck_rises = 0; oe_or = 4'h0; oe_and = 4'hf;
  endtask

  task automatic push_exp(input logic [7:0] b, input int lanes);
    for (int i = 7; i >= 0; i--) begin
      if (exp_n < 512) ebits[exp_n] = b[i];
      exp_n++;
    end
    exp_beats += 8 / lanes;
  endtask

  task automatic cmp_stream(input string req);
    int mis = 0;
    check(out_n == exp_n, req, "output bit count", 32'(out_n), 32'(exp_n));
    check(out_beats == exp_beats, req, "output beat count", 32'(out_beats), 32'(exp_beats));
    for (int i = 0; i < exp_n && i < 512; i++) if (obits[i] != ebits[i]) mis++;
    check(mis == 0, req, "output bit mismatches", 32'(mis), 32'd0);
  endtask

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] mkcfg(input logic [1:0] md, input bit stop,
      input logic [7:0] op, input logic [2:0] dm, input int ln);
    logic [31:0] v = 32'h0;
    v[1:0] = md; v[2] = stop; v[7:6] = dm[1:0]; v[14] = dm[2]; v[23:16] = op;
    if (ln == 2) v[29] = 1'b1;
    else if (ln == 4) v[30] = 1'b1;
    return v;
  endfunction

  logic [31:0] acc_rd;
  int          acc_lat;
  logic        acc_cs, acc_after;

  task automatic access(input bit we, input bit word, input logic [AW-1:0] a,
                        input logic [31:0] wd);
    @(negedge clk);
    win_req = 1'b1; win_we = we; win_word = word; win_addr = a; win_wdata = wd;
    acc_lat = 0;
    do begin
      @(negedge clk);
      acc_lat++;
    end while (!win_ready && acc_lat < 100000);
    acc_rd = win_rdata; acc_cs = spi_cs_n; win_req = 1'b0;
    @(negedge clk);
    acc_after = win_ready;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R13 watchdog act=hung exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, r, rexp, a32;
    logic [7:0]  op;
    logic [2:0]  dm;
    int          ln, aw, wd, ib;
    logic [AW-1:0] ad;
    v = $urandom(32'd20240611);
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wdata = 32'h0; addr_wide = 1'b0;
    win_req = 1'b0; win_we = 1'b0; win_word = 1'b0; win_addr = '0; win_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(spi_cs_n == 1'b1, "R1", "cs_n", 32'(spi_cs_n), 32'd1);
    check(spi_sck == 1'b0, "R1", "sck", 32'(spi_sck), 32'd0);
    check(spi_io_oe == 4'h0, "R1", "oe", 32'(spi_io_oe), 32'd0);
    check(win_ready == 1'b0, "R1", "ready", 32'(win_ready), 32'd0);
    check(cfg_rdata == 32'h4, "R1", "cfg", cfg_rdata, 32'h4);

    // R2 readback
    v = $urandom;
    cfg_write(v);
    check(cfg_rdata == v, "R2", "cfg readback", cfg_rdata, v);

    // R3 user mode chip select
    cfg_write(mkcfg(2'd3, 1'b1, 8'h00, 3'd0, 1));
    check(spi_cs_n == 1'b1, "R3", "cs_n with stop", 32'(spi_cs_n), 32'd1);
    cfg_write(mkcfg(2'd3, 1'b0, 8'h00, 3'd0, 1));
    check(spi_cs_n == 1'b0, "R3", "cs_n without stop", 32'(spi_cs_n), 32'd0);

    // R4 user word write, one lane
    clear_mon();
    tick_div = 2;
    v = $urandom;
    for (int i = 3; i >= 0; i--) push_exp(v[i*8 +: 8], 1);
    access(1'b1, 1'b1, '0, v);
    cmp_stream("R4");
    check(oe_or == 4'b0001 && oe_and == 4'b0001, "R11", "single oe", 32'(oe_or), 32'h1);

    // R4/R6 byte write on two lanes, word write on four lanes, same frame
    cfg_write(mkcfg(2'd3, 1'b0, 8'h00, 3'd0, 2));
    exp_n = 0; out_n = 0; out_beats = 0; exp_beats = 0; oe_or = 4'h0; oe_and = 4'hf;
    v = $urandom;
    push_exp(v[7:0], 2);
    access(1'b1, 1'b0, '0, v);
    cmp_stream("R6");
    check(oe_or == 4'b0011 && oe_and == 4'b0011, "R11", "dual oe", 32'(oe_or), 32'h3);
    cfg_write(mkcfg(2'd3, 1'b0, 8'h00, 3'd0, 4));
    exp_n = 0; out_n = 0; out_beats = 0; exp_beats = 0; oe_or = 4'h0; oe_and = 4'hf;
    v = $urandom;
    for (int i = 3; i >= 0; i--) push_exp(v[i*8 +: 8], 4);
    access(1'b1, 1'b1, '0, v);
    cmp_stream("R6");
    check(oe_or == 4'b1111 && oe_and == 4'b1111, "R11", "quad oe", 32'(oe_or), 32'hf);
    check(cs_falls == 0 && spi_cs_n == 1'b0, "R6", "cs kept across width change",
          32'(cs_falls), 32'd0);

    // R5 user reads
    cfg_write(mkcfg(2'd3, 1'b0, 8'h00, 3'd0, 1));
    clear_mon();
    r = $urandom; rlanes = 1; resp = r;
    access(1'b0, 1'b0, '0, 32'h0);
    check(acc_rd == {24'h0, r[31:24]}, "R5", "byte read single", acc_rd, {24'h0, r[31:24]});
    check(in_beats == 8, "R5", "input beats", 32'(in_beats), 32'd8);
    check(out_beats == 0, "R11", "oe released on input", 32'(out_beats), 32'd0);
    cfg_write(mkcfg(2'd3, 1'b0, 8'h00, 3'd0, 4));
    clear_mon();
    r = $urandom; rlanes = 4; resp = r;
    access(1'b0, 1'b1, '0, 32'h0);
    check(acc_rd == r, "R5", "word read quad", acc_rd, r);
    check(in_beats == 8, "R6", "quad input beats", 32'(in_beats), 32'd8);
    cfg_write(mkcfg(2'd3, 1'b1, 8'h00, 3'd0, 4));
    check(spi_cs_n == 1'b1, "R3", "cs_n after stop", 32'(spi_cs_n), 32'd1);

    // R8/R9 command reads, directed corners then random
    for (int k = 0; k < 24; k++) begin
      op = 8'($urandom);
      dm = (k == 0) ? 3'd7 : (k == 1) ? 3'd0 : 3'($urandom % 8);
      case ($urandom % 3) 0: ln = 1; 1: ln = 2; default: ln = 4; endcase
      if (k == 0) ln = 4;
      if (k == 1) ln = 1;
      aw = (k == 0) ? 1 : (k == 1) ? 0 : int'($urandom % 2);
      wd = (k == 0) ? 1 : (k == 1) ? 0 : int'($urandom % 2);
      ad = AW'($urandom);
      tick_div = 1 + int'($urandom % 3);
      cfg_write(mkcfg(2'd1, 1'b1, op, dm, ln));
      addr_wide = aw[0];
      clear_mon();
      a32 = 32'(ad);
      push_exp(op, 1);
      if (aw != 0) push_exp(a32[31:24], 1);
      push_exp(a32[23:16], 1); push_exp(a32[15:8], 1); push_exp(a32[7:0], 1);
      for (int d = 0; d < int'(dm); d++) push_exp(8'h00, 1);
      r = $urandom; rlanes = ln; resp = r;
      rexp = (wd != 0) ? r : {24'h0, r[31:24]};
      ib = ((wd != 0) ? 4 : 1) * 8 / ln;
      access(1'b0, wd[0], ad, 32'h0);
      cmp_stream((aw != 0) ? "R9" : "R8");
      check(acc_rd == rexp, "R8", "command read data", acc_rd, rexp);
      check(in_beats == ib, "R6", "data beats", 32'(in_beats), 32'(ib));
      check(oe_or == 4'b0001 && oe_and == 4'b0001, "R11", "header oe", 32'(oe_or), 32'h1);
      check(cs_falls == 1 && acc_cs == 1'b1, "R8", "cs framing", 32'(cs_falls), 32'd1);
      check(acc_after == 1'b0, "R13", "ready pulse width", 32'(acc_after), 32'd0);
      check(spi_sck == 1'b0, "R7", "clock idles low", 32'(spi_sck), 32'd0);
    end
    addr_wide = 1'b0;

    // R10 normal read ignores opcode, dummy and width
    cfg_write(mkcfg(2'd0, 1'b1, 8'hAB, 3'd5, 4));
    clear_mon();
    ad = AW'(32'h0012_3456);
    push_exp(8'h03, 1); push_exp(8'h12, 1); push_exp(8'h34, 1); push_exp(8'h56, 1);
    r = $urandom; rlanes = 1; resp = r;
    access(1'b0, 1'b1, ad, 32'h0);
    cmp_stream("R10");
    check(acc_rd == r, "R10", "normal read data", acc_rd, r);
    check(in_beats == 32, "R10", "single lane data", 32'(in_beats), 32'd32);

    // R12 unsupported or ignored accesses
    for (int m = 0; m < 4; m++) begin
      cfg_write(mkcfg((m == 3) ? 2'd2 : 2'(m), 1'b1, 8'h0B, 3'd1, 1));
      clear_mon();
      access((m == 3) ? 1'b0 : 1'b1, 1'b1, AW'($urandom), $urandom);
      check(acc_lat <= 2, "R12", "ack latency", 32'(acc_lat), 32'd2);
      check(cs_falls == 0 && sck_rises == 0, "R12", "no serial activity",
            32'(sck_rises), 32'd0);
      check(acc_rd == 32'h0, "R12", "read data zero", acc_rd, 32'h0);
    end

    check(viol == 0, "R7", "output change while clock high", 32'(viol), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule